// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor load/store port and a slower main-memory port. It holds recently used blocks in a two-way set-associative store. Each request address is split into a tag, a set index and a word select. Both ways of the selected set are searched at the same time. A hit is answered in the same cycle, with no memory traffic. A store hit changes only the bytes named by its byte-enable mask and marks the line dirty.

On a miss the controller raises `stall` and picks a victim way. An empty way is used first. When both ways are occupied, a per-set round-robin pointer chooses. A dirty victim is first written back to memory one word per beat. The block is then refilled one word per beat. After the refill the processor's request, which the processor holds steady while `stall` is high, is served again as an ordinary hit. A store miss therefore allocates the line first and then merges its bytes into it.

The controller has three states:
- `ST_IDLE` serves hits and detects misses.
- `ST_WRBACK` drains a dirty victim.
- `ST_REFILL` fetches the missing block.

Its transitions are:
- IDLE→WRBACK on a miss whose victim is valid and dirty.
- IDLE→REFILL on a miss whose victim is clean or empty.
- WRBACK→REFILL after the last write beat.
- REFILL→IDLE after the last read beat.

Top module: `cwb_cache`

## Requirements
- R1: With the default geometry (32-bit address, 8-byte words, 64-byte blocks, 64 KiB), the word select is addr[5:3], the set index is addr[14:6] and the tag is addr[31:15]. Address bits [2:0] do not affect which word is returned.
- R2: When `req_valid` is high and either way of the set holds a valid line with a matching tag, `rsp_valid` is high and `stall` is low in that same cycle, `rsp_rdata` is the stored word, and `mem_valid` stays low.
- R3: On a miss, `stall` is high and `rsp_valid` is low until the block has been fetched in 8 read beats. The beats carry `mem_write`=0, use word-aligned addresses {tag, set, beat, 3'b000}, and run in ascending beat order 0..7. The held request then completes as a hit.
- R4: On a store hit, byte i (bits 8i+7:8i) of the word changes only where `req_be[i]`=1, and the line becomes dirty.
- R5: A store miss allocates the block by refilling it from memory, then merges the store into it. A later load of that word returns the merged value without memory traffic.
- R6: The victim is the first invalid way, way 0 before way 1. When both ways are valid, the set's round-robin pointer selects the victim. After each refill the pointer is set to the way that was not filled.
- R7: A dirty victim is written back with 8 write beats (`mem_write`=1) carrying its old tag and data, before any refill beat. A clean or empty victim causes no write beats.
- R8: A beat transfers in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_valid`, `mem_write` and `mem_addr` hold steady.
- R9: Reset empties every line, clears all dirty bits and sets all round-robin pointers to way 0. With no request pending, `stall`, `rsp_valid` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present, held while stalled |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| stall | output | 1 | Request cannot complete this cycle |
| rsp_valid | output | 1 | Request completes this cycle |
| rsp_rdata | output | 64 | Load data |
| mem_valid | output | 1 | Memory beat requested |
| mem_write | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | 64 | Write-back beat data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 64 | Refill beat data, valid with mem_ready |

## Verification
The bound checker watches every cycle for the following properties:
- A response never coincides with a stall and always has a request behind it.
- Memory is idle whenever the processor is not stalled.
- Beat addresses are word aligned and do not change while memory holds off.
- A finished write-back always leads straight into a refill.

Some behaviour can only be shown by the bench's scenarios, which compare against a reference model of memory contents:
- Data values and byte-enable merging.
- Which way the round-robin pointer evicts.
- That a clean victim produces no write beats.
- That a dirty victim's old contents actually reach memory.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRBACK = 2'd1,
        ST_REFILL = 2'd2
    } cwb_state_e;

endpackage

// File: rtl/cwb_addr_split.sv
module cwb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 17,
    parameter int SET_W  = 9,
    parameter int BEAT_W = 3,
    parameter int BSEL_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [SET_W-1:0]  set,
    output logic [BEAT_W-1:0] word
);
    logic unused_bsel;

    assign word        = addr[BSEL_W +: BEAT_W];
    assign set         = addr[BSEL_W + BEAT_W +: SET_W];
    assign tag         = addr[ADDR_W-1 -: TAG_W];
    assign unused_bsel = ^addr[BSEL_W-1:0];
endmodule

// File: rtl/cwb_way_store.sv
module cwb_way_store #(
    parameter int NSETS  = 512,
    parameter int SET_W  = 9,
    parameter int TAG_W  = 17,
    parameter int WORD_W = 64,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [BEAT_W-1:0] lk_word,
    output logic              lk_hit,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic [TAG_W-1:0]  lk_tag_o,
    output logic [WORD_W-1:0] lk_word_o,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W/8-1:0] wr_be,
    input  logic              wr_dirty,
    input  logic              fill_done,
    input  logic [TAG_W-1:0]  fill_tag
);
    localparam int BE_W   = WORD_W / 8;
    localparam int BSEL_W = $clog2(BE_W);
    localparam int WSH    = $clog2(WORD_W);
    localparam int LINE_W = WORD_W << BEAT_W;

    logic [NSETS-1:0]  valid_q;
    logic [NSETS-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [NSETS];
    logic [LINE_W-1:0] line_q [NSETS];
    logic [BEAT_W+WSH-1:0] wbase;

    assign wbase     = {lk_word, {WSH{1'b0}}};
    assign lk_valid  = valid_q[lk_set];
    assign lk_dirty  = dirty_q[lk_set];
    assign lk_tag_o  = tag_q[lk_set];
    assign lk_hit    = lk_valid && (tag_q[lk_set] == lk_tag);
    assign lk_word_o = line_q[lk_set][wbase +: WORD_W];

    // status bits: cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_done) begin
            valid_q[lk_set] <= 1'b1;
            dirty_q[lk_set] <= 1'b0;
        end else if (wr_dirty) begin
            dirty_q[lk_set] <= 1'b1;
        end
    end

    // tag and data arrays: no reset, gated by valid
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[lk_set] <= fill_tag;
        end
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    line_q[lk_set][{lk_word, b[BSEL_W-1:0], 3'b000} +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
    import cwb_pkg::*;
#(
    parameter int NSETS  = 512,
    parameter int SET_W  = 9,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [1:0]        way_hit,
    input  logic [1:0]        way_valid,
    input  logic [1:0]        way_dirty,
    input  logic              mem_ready,
    output cwb_state_e        state_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              vic_o,
    output logic              miss_start,
    output logic              stall,
    output logic              rsp_valid,
    output logic              fill_we,
    output logic              fill_done,
    output logic              mem_valid,
    output logic              mem_write
);
    cwb_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              vic_q, vic_pick;
    logic [NSETS-1:0]  rr_q;
    logic              last_beat;

    assign state_o = state_q;
    assign beat_o  = beat_q;
    assign vic_o   = vic_q;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            vic_q   <= 1'b0;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (miss_start) begin
                vic_q  <= vic_pick;
                beat_q <= '0;
            end else if (mem_valid && mem_ready) begin
                beat_q <= beat_q + 1'b1;
            end
            if (fill_done) begin
                rr_q[lk_set] <= ~vic_q;
            end
        end
    end

    // next state and outputs
    always_comb begin
        last_beat  = (beat_q == {BEAT_W{1'b1}});
        vic_pick   = !way_valid[0] ? 1'b0 :
                     !way_valid[1] ? 1'b1 : rr_q[lk_set];
        state_d    = state_q;
        miss_start = 1'b0;
        rsp_valid  = 1'b0;
        stall      = 1'b1;
        fill_we    = 1'b0;
        fill_done  = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                stall = 1'b0;
                if (req_valid) begin
                    if (|way_hit) begin
                        rsp_valid = 1'b1;
                    end else begin
                        stall      = 1'b1;
                        miss_start = 1'b1;
                        state_d    = (way_valid[vic_pick] && way_dirty[vic_pick])
                                     ? ST_WRBACK : ST_REFILL;
                    end
                end
            end
            ST_WRBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                if (mem_ready && last_beat) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                fill_we   = mem_ready;
                if (mem_ready && last_beat) begin
                    fill_done = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
    import cwb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 8,
    parameter int BLOCK_BYTES = 64,
    parameter int CACHE_BYTES = 65536
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_BYTES*8-1:0] req_wdata,
    input  logic [WORD_BYTES-1:0]   req_be,
    output logic                    stall,
    output logic                    rsp_valid,
    output logic [WORD_BYTES*8-1:0] rsp_rdata,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_BYTES*8-1:0] mem_wdata,
    input  logic                    mem_ready,
    input  logic [WORD_BYTES*8-1:0] mem_rdata
);
    localparam int NWAYS  = 2;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int NBEATS = BLOCK_BYTES / WORD_BYTES;
    localparam int BEAT_W = $clog2(NBEATS);
    localparam int BSEL_W = $clog2(WORD_BYTES);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int NSETS  = CACHE_BYTES / (BLOCK_BYTES * NWAYS);
    localparam int SET_W  = $clog2(NSETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    cwb_state_e        st;
    logic [TAG_W-1:0]  req_tag, miss_tag_q;
    logic [SET_W-1:0]  req_set, miss_set_q, lk_set;
    logic [BEAT_W-1:0] req_word, beat, lk_word;
    logic              vic, miss_start, fill_we, fill_done, hit_we;
    logic [NWAYS-1:0]  way_hit, way_valid, way_dirty;
    logic [NWAYS-1:0][TAG_W-1:0]  way_tag;
    logic [NWAYS-1:0][WORD_W-1:0] way_word;

    cwb_addr_split #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SET_W(SET_W), .BEAT_W(BEAT_W), .BSEL_W(BSEL_W)
    ) u_split (
        .addr(req_addr), .tag(req_tag), .set(req_set), .word(req_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_tag_q <= '0;
            miss_set_q <= '0;
        end else if (miss_start) begin
            miss_tag_q <= req_tag;
            miss_set_q <= req_set;
        end
    end

    assign lk_set  = (st == ST_IDLE) ? req_set  : miss_set_q;
    assign lk_word = (st == ST_IDLE) ? req_word : beat;
    assign hit_we  = rsp_valid && req_write;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        cwb_way_store #(
            .NSETS(NSETS), .SET_W(SET_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .BEAT_W(BEAT_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_set    (lk_set),
            .lk_tag    (req_tag),
            .lk_word   (lk_word),
            .lk_hit    (way_hit[w]),
            .lk_valid  (way_valid[w]),
            .lk_dirty  (way_dirty[w]),
            .lk_tag_o  (way_tag[w]),
            .lk_word_o (way_word[w]),
            .wr_en     ((hit_we && way_hit[w]) || (fill_we && (vic == w))),
            .wr_data   (fill_we ? mem_rdata : req_wdata),
            .wr_be     (fill_we ? {WORD_BYTES{1'b1}} : req_be),
            .wr_dirty  (hit_we && way_hit[w]),
            .fill_done (fill_done && (vic == w)),
            .fill_tag  (miss_tag_q)
        );
    end

    cwb_ctrl #(.NSETS(NSETS), .SET_W(SET_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lk_set     (lk_set),
        .way_hit    (way_hit),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .mem_ready  (mem_ready),
        .state_o    (st),
        .beat_o     (beat),
        .vic_o      (vic),
        .miss_start (miss_start),
        .stall      (stall),
        .rsp_valid  (rsp_valid),
        .fill_we    (fill_we),
        .fill_done  (fill_done),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write)
    );

    assign rsp_rdata = way_hit[1] ? way_word[1] : way_word[0];
    assign mem_wdata = way_word[vic];
    assign mem_addr  = (st == ST_WRBACK)
                       ? {way_tag[vic], miss_set_q, beat, {BSEL_W{1'b0}}}
                       : {miss_tag_q,   miss_set_q, beat, {BSEL_W{1'b0}}};
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker
    import cwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              stall,
    input logic              rsp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input cwb_state_e        st,
    input logic [BEAT_W-1:0] beat
);
    AST_RSP_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !stall); // R2
    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_valid); // R2
    AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> !mem_valid); // R9
    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[2:0] == 3'b000)); // R3
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R8
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRBACK && mem_ready && beat == {BEAT_W{1'b1}}) |=> (st == ST_REFILL)); // R7
endmodule

bind cwb_cache cwb_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .stall(stall),
    .rsp_valid(rsp_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .st(st), .beat(beat)
);

// File: tb/cwb_cache_test.sv
module cwb_cache_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        stall, rsp_valid, mem_valid, mem_write;
    logic [63:0] rsp_rdata, mem_wdata;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    int rd_beats = 0, wr_beats = 0, rd_seq = 0, wr_seq = 0, rdy_cnt = 0;
    logic [63:0] backing [logic [31:0]];
    logic [63:0] ref_mem [logic [31:0]];
    logic [63:0] exp_q [$];
    logic [31:0] exp_a [$];

    cwb_cache uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] pattern(input logic [31:0] a);
        return {a ^ 32'h5A5A_0F0F, ~a};
    endfunction

    function automatic logic [63:0] mem_read(input logic [31:0] a);
        return backing.exists(a) ? backing[a] : pattern(a);
    endfunction

    function automatic logic [63:0] ref_read(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : pattern(a);
    endfunction

    function automatic logic [31:0] adr(input int tag, input int set, input int w);
        return {tag[16:0], set[8:0], w[2:0], 3'b000};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: ready pattern and read data
    always @(negedge clk) begin
        rdy_cnt++;
        mem_ready = (rdy_cnt % 4) != 3;
        mem_rdata = mem_read(mem_addr);
    end

    // monitor: responses and memory beats, sampled mid low phase
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (req_valid && rsp_valid && !req_write) begin
            if (exp_q.size() == 0) chk("R2", "unexpected response", 1, 0);
            else chk("R2", $sformatf("load data @%0h", exp_a.pop_front()), rsp_rdata, exp_q.pop_front());
        end
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                chk("R7", "write beat order", mem_addr[5:3], wr_seq[2:0]);
                backing[{mem_addr[31:3], 3'b000}] = mem_wdata;
                wr_beats++; wr_seq++;
            end else begin
                chk("R3", "refill beat order", mem_addr[5:3], rd_seq[2:0]);
                rd_beats++; rd_seq++;
            end
        end
    end

    // driver: one access, returns stall cycles
    task automatic access(input logic w, input logic [31:0] a, input logic [63:0] d,
                          input logic [7:0] be, output int cyc);
        logic [31:0] k;
        logic [63:0] v;
        k = {a[31:3], 3'b000};
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        if (w) begin
            v = ref_read(k);
            for (int b = 0; b < 8; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
            ref_mem[k] = v;
        end else begin
            exp_q.push_back(ref_read(k));
            exp_a.push_back(a);
        end
        cyc = 0;
        #(CLK_PERIOD/4);
        while (!rsp_valid && cyc < 2000) begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            cyc++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c, r0, w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk("R9", "stall after reset", stall, 0);
        chk("R9", "mem_valid after reset", mem_valid, 0);
        chk("R9", "rsp_valid after reset", rsp_valid, 0);

        // cold read miss into empty set
        r0 = rd_beats; w0 = wr_beats;
        access(0, adr(1,5,2), 0, 0, c);
        chk("R3", "miss stalls", c > 0, 1);
        chk("R3", "refill beats", rd_beats - r0, 8);
        chk("R7", "no write-back of empty way", wr_beats - w0, 0);

        // hit in same line
        r0 = rd_beats;
        access(0, adr(1,5,7), 0, 0, c);
        chk("R2", "hit no stall", c, 0);
        chk("R2", "hit no memory traffic", rd_beats - r0, 0);

        // store hit with partial byte enables
        access(1, adr(1,5,2), 64'h1111_2222_3333_4444, 8'h0F, c);
        chk("R4", "store hit no stall", c, 0);
        access(0, adr(1,5,2), 0, 0, c);

        // second tag fills the empty way
        r0 = rd_beats; w0 = wr_beats;
        access(0, adr(2,5,0), 0, 0, c);
        chk("R6", "fill of invalid way", rd_beats - r0, 8);
        chk("R6", "no eviction when a way is empty", wr_beats - w0, 0);
        access(0, adr(1,5,2), 0, 0, c);
        chk("R6", "way0 still resident", c, 0);
        access(0, adr(2,5,0), 0, 0, c);
        chk("R6", "way1 resident", c, 0);

        // third tag: pointer picks way0, which is dirty
        r0 = rd_beats; w0 = wr_beats;
        access(0, adr(3,5,1), 0, 0, c);
        chk("R7", "dirty victim write beats", wr_beats - w0, 8);
        chk("R3", "refill after write-back", rd_beats - r0, 8);
        chk("R7", "written-back word", mem_read(adr(1,5,2)), ref_read(adr(1,5,2)));
        access(0, adr(2,5,0), 0, 0, c);
        chk("R6", "other way untouched", c, 0);

        // pointer now selects way1 (tag 2, clean)
        w0 = wr_beats;
        access(0, adr(1,5,2), 0, 0, c);
        chk("R6", "re-miss on evicted tag", c > 0, 1);
        chk("R7", "clean victim no write beats", wr_beats - w0, 0);
        access(0, adr(3,5,1), 0, 0, c);
        chk("R6", "round robin kept way0", c, 0);
        access(0, adr(2,5,0), 0, 0, c);
        chk("R6", "tag 2 was evicted", c > 0, 1);

        // store miss allocates, then merges
        r0 = rd_beats;
        access(1, adr(4,9,1), 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, c);
        chk("R5", "store miss refills", rd_beats - r0, 8);
        r0 = rd_beats;
        access(0, adr(4,9,1), 0, 0, c);
        chk("R5", "merged word hits", c, 0);
        access(0, adr(4,9,3), 0, 0, c);
        chk("R5", "rest of allocated line hits", rd_beats - r0, 0);
        access(0, adr(5,9,0), 0, 0, c);
        w0 = wr_beats;
        access(0, adr(6,9,0), 0, 0, c);
        chk("R7", "allocated dirty line written back", wr_beats - w0, 8);
        chk("R5", "merged store reached memory", mem_read(adr(4,9,1)), 64'hDEAD_BEEF_CAFE_F00D);

        // low address bits and set independence
        access(0, adr(1,5,2) | 32'h5, 0, 0, c);
        chk("R1", "byte offset bits ignored, hit", c, 0);
        access(0, adr(1,6,0), 0, 0, c);
        chk("R1", "other set misses", c > 0, 1);
        access(0, adr(1,5,2), 0, 0, c);
        chk("R1", "set 5 unaffected by set 6", c, 0);

        repeat (4) @(negedge clk);
        chk("R2", "all loads answered", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule